// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block loads one transfer descriptor from a descriptor table into a set of field registers. The table holds 60 descriptors. Each descriptor takes eight 16-bit words, and descriptor `n` starts at word address `8*n`. The caller gives a descriptor number, the number of the requesting channel and a space select (memory or IO), then pulses `start_i`.

The sequencer always reads the mode/link word first and decodes the transfer mode from its bit 15. After that it reads, in ascending order, only the words that this mode and this channel need. A plain transfer needs the block length and the first area's address and attribute words. An area-to-area transfer also needs the second area's address and attribute words. Channels 0 and 1 additionally need the interval word. Word 7 is never read.

Reads use a request/acknowledge interface that allows one outstanding read. `done_o` pulses once all the needed fields have been latched. A descriptor number outside the table raises `err_o` and no read is made.

Top module: `desc_fetch_seq`

## Requirements
- R1: After reset, `rd_req_o`, `busy_o`, `done_o` and `err_o` are 0, and every field output is 0.
- R2: An accepted start with a descriptor number `n` ≤ 59 first requests address `8*n` (word 0, the mode/link word) and latches that word into `mode_o`.
- R3: When bit 15 of the mode word is 0, the only further reads are words 1, 2 and 3, in that order. These words land in `len_o`, `a1_base_o` and `a1_attr_o`. `a2_base_o`, `a2_attr_o` and `interval_o` read 0.
- R4: When bit 15 is 1 and the channel is 0 or 1, the further reads are words 1 to 6 in ascending order. Words 4, 5 and 6 land in `a2_base_o`, `a2_attr_o` and `interval_o`.
- R5: When bit 15 is 1 and the channel is 2 or 3, the further reads are words 1 to 5 in ascending order, and `interval_o` reads 0.
- R6: Word 7 of a descriptor is never requested, and no address above 0x1DF is requested.
- R7: `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ack_i` is seen. The field for that word is loaded from `rd_data_i` on the acknowledge cycle.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last needed word is acknowledged. In that cycle `busy_o` and `rd_req_o` are low and all fields hold their final values.
- R9: A start with a descriptor number of 60 or more gives a one-cycle `err_o` in the next cycle. It makes no read and leaves `busy_o` low.
- R10: A start that arrives while `busy_o` is high is ignored. The reads and fields belong only to the fetch already in progress.
- R11: `rd_space_o` equals the `space_i` value captured at the accepted start, for every read of that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a fetch (ignored while busy) |
| desc_num_i | input | 6 | Descriptor number |
| chan_i | input | 2 | Requesting channel |
| space_i | input | 1 | Table space: 0 memory, 1 IO |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 9 | Word address of the read |
| rd_space_o | output | 1 | Space of the read |
| rd_ack_i | input | 1 | Read acknowledge; data valid |
| rd_data_i | input | 16 | Read data |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle bad descriptor number pulse |
| mode_o | output | 16 | Word 0, mode/link |
| len_o | output | 16 | Word 1, block length |
| a1_base_o | output | 16 | Word 2, first area base |
| a1_attr_o | output | 16 | Word 3, first area attributes |
| a2_base_o | output | 16 | Word 4, second area base |
| a2_attr_o | output | 16 | Word 5, second area attributes |
| interval_o | output | 16 | Word 6, transfer interval |

## Verification
The hardest situation to reach from the ports is a second start that lands in the middle of a fetch whose mode is not yet known. If that start leaked through, the read list would mix two descriptors. The bench slows the acknowledge by several cycles so the fetch stays busy, and pulses a start for a different descriptor and channel while the first read is still open. It then compares the full list of addresses read against the first descriptor alone. Word-7 skipping and the channel-dependent interval skip are covered at the table's last descriptor, where a stray read of word 7 would reach address 0x1DF.

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq #(
  parameter int NUM_DESC = 60,
  parameter int DW       = 16,
  parameter int IDX_W    = 3,
  parameter int CH_W     = 2,
  parameter int IV_CHANS = 2,
  parameter int MODE_BIT = 15
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic [$clog2(NUM_DESC)-1:0]     desc_num_i,
  input  logic [CH_W-1:0]                 chan_i,
  input  logic                            space_i,
  output logic                            rd_req_o,
  output logic [$clog2(NUM_DESC)+IDX_W-1:0] rd_addr_o,
  output logic                            rd_space_o,
  input  logic                            rd_ack_i,
  input  logic [DW-1:0]                   rd_data_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic                            err_o,
  output logic [DW-1:0]                   mode_o,
  output logic [DW-1:0]                   len_o,
  output logic [DW-1:0]                   a1_base_o,
  output logic [DW-1:0]                   a1_attr_o,
  output logic [DW-1:0]                   a2_base_o,
  output logic [DW-1:0]                   a2_attr_o,
  output logic [DW-1:0]                   interval_o
);
  localparam int DN_W = $clog2(NUM_DESC);
  localparam int NFLD = (1 << IDX_W) - 1;
  localparam logic [DN_W-1:0]  LAST_DESC = DN_W'(NUM_DESC - 1);
  localparam logic [IDX_W-1:0] LAST_PLAIN = IDX_W'(3);
  localparam logic [IDX_W-1:0] LAST_A2A   = IDX_W'(5);
  localparam logic [IDX_W-1:0] LAST_IV    = IDX_W'(6);

  logic              busy_q, done_q, err_q, sp_q, a2a_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DN_W-1:0]   dn_q;
  logic [CH_W-1:0]   ch_q;
  logic [DW-1:0]     fld_q [NFLD];

  wire accept  = start_i && !busy_q;
  wire bad_num = desc_num_i > LAST_DESC;
  wire a2a_now = (idx_q == '0) ? rd_data_i[MODE_BIT] : a2a_q;
  wire iv_chan = ch_q < CH_W'(IV_CHANS);
  wire [IDX_W-1:0] last_idx = !a2a_now ? LAST_PLAIN : (iv_chan ? LAST_IV : LAST_A2A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      sp_q   <= 1'b0;
      a2a_q  <= 1'b0;
      idx_q  <= '0;
      dn_q   <= '0;
      ch_q   <= '0;
      for (int i = 0; i < NFLD; i++) fld_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (bad_num) begin
          err_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          dn_q   <= desc_num_i;
          ch_q   <= chan_i;
          sp_q   <= space_i;
          a2a_q  <= 1'b0;
          for (int i = 0; i < NFLD; i++) fld_q[i] <= '0;
        end
      end else if (busy_q && rd_ack_i) begin
        fld_q[idx_q] <= rd_data_i;
        if (idx_q == '0) a2a_q <= rd_data_i[MODE_BIT];
        if (idx_q == last_idx) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign rd_req_o   = busy_q;
  assign rd_addr_o  = {dn_q, idx_q};
  assign rd_space_o = sp_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign mode_o     = fld_q[0];
  assign len_o      = fld_q[1];
  assign a1_base_o  = fld_q[2];
  assign a1_attr_o  = fld_q[3];
  assign a2_base_o  = fld_q[4];
  assign a2_attr_o  = fld_q[5];
  assign interval_o = fld_q[6];
endmodule

module desc_fetch_chk #(
  parameter int AW       = 9,
  parameter int NUM_DESC = 60
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o
);
  localparam logic [AW-1:0] LIMIT = AW'(NUM_DESC * 8);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  assert_no_word7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_addr_o[2:0] != 3'd7) && (rd_addr_o < LIMIT));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !rd_req_o);
  assert_err_noread_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o && !rd_req_o && !done_o);
endmodule

bind desc_fetch_seq desc_fetch_chk #(.AW($clog2(NUM_DESC) + IDX_W), .NUM_DESC(NUM_DESC)) u_chk (.*);

// File: tb/sim_desc_fetch_seq.sv
`timescale 1ns/1ps
module sim_desc_fetch_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, space = 1'b0;
  logic [5:0] dnum = '0;
  logic [1:0] chan = '0;
  logic rd_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic rd_req, rd_space, busy, done, err;
  logic [8:0] rd_addr;
  logic [15:0] f_mode, f_len, f_a1b, f_a1a, f_a2b, f_a2a, f_iv;

  int n_chk = 0, n_fail = 0, cyc = 0, lat = 0, wcnt = 0, nlog = 0;
  int log_addr [32];
  int log_sp [32];
  logic [15:0] mem [480];

  always #5 clk = ~clk;

  desc_fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .desc_num_i(dnum), .chan_i(chan),
    .space_i(space), .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_space_o(rd_space),
    .rd_ack_i(rd_ack), .rd_data_i(rd_data), .busy_o(busy), .done_o(done), .err_o(err),
    .mode_o(f_mode), .len_o(f_len), .a1_base_o(f_a1b), .a1_attr_o(f_a1a),
    .a2_base_o(f_a2b), .a2_attr_o(f_a2a), .interval_o(f_iv));

  function automatic logic [15:0] val(int a, int sp);
    return mem[a] ^ (sp != 0 ? 16'h00FF : 16'h0000);
  endfunction

  function automatic logic [15:0] fld(int k);
    case (k)
      0: return f_mode; 1: return f_len; 2: return f_a1b; 3: return f_a1a;
      4: return f_a2b;  5: return f_a2a; default: return f_iv;
    endcase
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
      if (rd_ack) rd_ack = 1'b0;
      else if (rd_req) begin
        if (wcnt >= lat) begin
          rd_ack = 1'b1;
          rd_data = (rd_addr < 480) ? val(int'(rd_addr), int'(rd_space)) : 16'hDEAD;
          if (nlog < 32) begin
            log_addr[nlog] = int'(rd_addr);
            log_sp[nlog] = int'(rd_space);
          end
          nlog++;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic do_start(int dn, int ch, int sp);
    @(negedge clk);
    nlog = 0;
    start = 1'b1; dnum = 6'(dn); chan = 2'(ch); space = sp[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string rq);
    int t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    chk({rq, " done seen"}, done, 1);
    chk("R8 busy low at done", busy, 0);
    chk("R8 req low at done", rd_req, 0);
  endtask

  task automatic verify(int dn, int ch, int sp, bit a2a, string rq);
    int last = !a2a ? 3 : (ch < 2 ? 6 : 5);
    chk({rq, " read count"}, nlog, last + 1);
    for (int k = 0; k <= last && k < nlog; k++) begin
      chk({rq, " read addr order"}, log_addr[k], dn * 8 + k);
      chk("R11 read space", log_sp[k], sp);
    end
    for (int k = 0; k < 7; k++)
      chk({rq, " field value"}, fld(k), k <= last ? val(dn * 8 + k, sp) : 16'h0);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk("R1 req", rd_req, 0); chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);  chk("R1 err", err, 0);
    for (int k = 0; k < 7; k++) chk("R1 field zero", fld(k), 0);
  endtask

  task automatic t_plain();
    mem[24] = mem[24] & 16'h7FFF; lat = 0;
    do_start(3, 0, 0);
    chk("R2 first addr word0", rd_addr, 24);
    chk("R7 req high", rd_req, 1);
    wait_done("R3");
    verify(3, 0, 0, 0, "R3");
  endtask

  task automatic t_a2a_last();
    mem[472] = mem[472] | 16'h8000; lat = 2;
    do_start(59, 1, 0);
    wait_done("R4");
    verify(59, 1, 0, 1, "R4");
    chk("R6 word7 untouched", nlog, 7);
  endtask

  task automatic t_a2a_ch2();
    mem[0] = mem[0] | 16'h8000; lat = 1;
    do_start(0, 2, 0);
    wait_done("R5");
    verify(0, 2, 0, 1, "R5");
  endtask

  task automatic t_io_ch3();
    mem[80] = mem[80] | 16'h8000; lat = 0;
    do_start(10, 3, 1);
    wait_done("R11");
    verify(10, 3, 1, 1, "R11");
  endtask

  task automatic t_clear();
    mem[40] = mem[40] | 16'h8000; lat = 0;
    do_start(5, 0, 0); wait_done("R4"); verify(5, 0, 0, 1, "R4");
    mem[48] = mem[48] & 16'h7FFF;
    do_start(6, 1, 0); wait_done("R3"); verify(6, 1, 0, 0, "R3 skipped cleared");
  endtask

  task automatic t_bad(int dn);
    logic [15:0] keep = f_len;
    do_start(dn, 0, 0);
    chk("R9 err pulse", err, 1);
    chk("R9 not busy", busy, 0);
    @(negedge clk);
    chk("R9 err one cycle", err, 0);
    repeat (4) @(negedge clk);
    chk("R9 no reads", nlog, 0);
    chk("R9 fields kept", f_len, keep);
  endtask

  task automatic t_busy_start();
    mem[160] = mem[160] & 16'h7FFF; mem[320] = mem[320] | 16'h8000; lat = 3;
    do_start(20, 2, 0);
    @(negedge clk);
    start = 1'b1; dnum = 6'd40; chan = 2'd0; space = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    verify(20, 2, 0, 0, "R10");
  endtask

  initial begin
    for (int i = 0; i < 480; i++) mem[i] = 16'((i * 37 + 5) & 16'h7FFF);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_a2a_last();
    t_a2a_ch2();
    t_io_ch3();
    t_clear();
    t_bad(60);
    t_bad(63);
    t_busy_start();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule